// File: doc/BRIEF.md
# TFT Panel Power-Up Sequencer

This block brings a small TFT display controller from power-on to a displaying state. A one-cycle start pulse makes it hold the panel's reset pin low for a fixed number of clock cycles and then wait for the panel to recover. It then plays out a fixed list of command and parameter bytes, with millisecond pauses at the points where the panel needs time to settle. The list is stored in an internal table whose entries each hold a data/command flag, a byte and a pause length. When the last pause ends, a done flag rises and stays high.

Bytes leave on a valid/ready stream. The serial link to the panel sits downstream. A word is presented with `m_valid_o` high and is transferred on any rising edge where `m_ready_i` is also high. While ready is low, the word and its flag are held unchanged. Valid never drops before the transfer completes. Pauses are timed by a prescaler that produces one tick every `CYC_PER_MS` clock cycles. No word is offered while a pause or the reset phase is running.

Top module: `lcd_pwrup_seq`

## Requirements
- R1: While `rst_ni` is low and afterwards until a start pulse, `m_valid_o` and `done_o` are 0 and `lcd_rst_no` is 1.
- R2: A start pulse drives `lcd_rst_no` low for exactly `RST_CYC` clock cycles, and no word is offered while it is low.
- R3: After `lcd_rst_no` returns high, the first word is offered no sooner than `RECOVER_MS*CYC_PER_MS` cycles later and no later than 4 cycles beyond that.
- R4: The words transferred are, in order, with flag 0 for a command and 1 for a parameter:
  - command C1 with parameters FF 83 40;
  - command 11;
  - command CA with parameters 70 00 D9;
  - command B0 with parameters 01 11;
  - command C9 with parameters 90 49 10 28 28 10 00 06;
  - command B5 with parameters 35 20 45;
  - command B4 with parameters 33 25 4C;
  - command 3A with parameter 05 (16 bits per pixel);
  - command 29.

  That makes 32 words in all, all in hex.
- R5: While `m_valid_o` is high and `m_ready_i` is low, the next cycle keeps `m_valid_o` high with the same `m_data_o` and `m_dc_o`.
- R6: A word that has no pause after it is followed by the next word in the very next cycle.
- R7: Pauses follow four words: 150 ms after command 11, 20 ms after the final C9 parameter 06, 10 ms after parameter 4C, and 10 ms after command 29. After each of these, the next word (or done) comes between N*`CYC_PER_MS` and N*`CYC_PER_MS`+4 cycles after the transfer.
- R8: `done_o` rises only after the final pause has elapsed. It then stays high, and no word is offered while it is high.
- R9: A start pulse that arrives while the sequence is running, during reset, recovery, word output or a pause, has no effect.
- R10: A start pulse while `done_o` is high clears `done_o` and replays the whole sequence from the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| lcd_rst_no | output | 1 | Panel hardware reset, active low |
| m_valid_o | output | 1 | Stream word valid |
| m_ready_i | input | 1 | Stream word ready |
| m_dc_o | output | 1 | 0 = command byte, 1 = parameter byte |
| m_data_o | output | 8 | Stream byte |
| done_o | output | 1 | Sequence complete |

## Verification
A table index that is off by one shows up at the stream as a wrong byte or a wrong flag on the very next transfer. A pause attached to the wrong entry shows up as a gap of one cycle where a long one is due, or the reverse. That is visible at the following word.

A prescaler or millisecond counter that counts wrongly moves the first word after reset, and every later pause, outside a window of a few cycles. A state machine that re-accepts start while busy shows up as a second low pulse on the panel reset pin within one cycle of the stray pulse.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int BYTE_W = 8;
  localparam int MS_W   = 8;
  localparam int STEPS  = 32;
  localparam int IDX_W  = $clog2(STEPS);

  typedef struct packed {
    logic              is_data;
    logic [BYTE_W-1:0] val;
    logic [MS_W-1:0]   wait_ms;
  } step_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_REC, S_EMIT, S_WAIT, S_DONE
  } seq_state_t;
endpackage

// File: rtl/lps_rom.sv
module lps_rom
  import lps_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o
);
  function automatic step_t c(input logic [7:0] v, input logic [7:0] w);
    return '{is_data: 1'b0, val: v, wait_ms: w};
  endfunction
  function automatic step_t p(input logic [7:0] v, input logic [7:0] w);
    return '{is_data: 1'b1, val: v, wait_ms: w};
  endfunction

  always_comb begin
    unique case (idx_i)
      5'd0:  step_o = c(8'hC1, 8'd0);
      5'd1:  step_o = p(8'hFF, 8'd0);
      5'd2:  step_o = p(8'h83, 8'd0);
      5'd3:  step_o = p(8'h40, 8'd0);
      5'd4:  step_o = c(8'h11, 8'd150);
      5'd5:  step_o = c(8'hCA, 8'd0);
      5'd6:  step_o = p(8'h70, 8'd0);
      5'd7:  step_o = p(8'h00, 8'd0);
      5'd8:  step_o = p(8'hD9, 8'd0);
      5'd9:  step_o = c(8'hB0, 8'd0);
      5'd10: step_o = p(8'h01, 8'd0);
      5'd11: step_o = p(8'h11, 8'd0);
      5'd12: step_o = c(8'hC9, 8'd0);
      5'd13: step_o = p(8'h90, 8'd0);
      5'd14: step_o = p(8'h49, 8'd0);
      5'd15: step_o = p(8'h10, 8'd0);
      5'd16: step_o = p(8'h28, 8'd0);
      5'd17: step_o = p(8'h28, 8'd0);
      5'd18: step_o = p(8'h10, 8'd0);
      5'd19: step_o = p(8'h00, 8'd0);
      5'd20: step_o = p(8'h06, 8'd20);
      5'd21: step_o = c(8'hB5, 8'd0);
      5'd22: step_o = p(8'h35, 8'd0);
      5'd23: step_o = p(8'h20, 8'd0);
      5'd24: step_o = p(8'h45, 8'd0);
      5'd25: step_o = c(8'hB4, 8'd0);
      5'd26: step_o = p(8'h33, 8'd0);
      5'd27: step_o = p(8'h25, 8'd0);
      5'd28: step_o = p(8'h4C, 8'd10);
      5'd29: step_o = c(8'h3A, 8'd0);
      5'd30: step_o = p(8'h05, 8'd0);
      default: step_o = c(8'h29, 8'd10);
    endcase
  end
endmodule

// File: rtl/lps_ms_timer.sv
module lps_ms_timer
  import lps_pkg::*;
#(
  parameter int CYC_PER_MS = 50000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] load_ms_i,
  output logic            expired_o
);
  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [MS_W-1:0]  ms_left;
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_left <= '0;
      pre     <= '0;
    end else if (load_i) begin
      ms_left <= load_ms_i;
      pre     <= '0;
    end else if (ms_left != '0) begin
      if (pre == PRE_LAST) begin
        pre     <= '0;
        ms_left <= ms_left - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expired_o = (ms_left == '0);

  // R7: the prescaler never passes its wrap value
  a_r7_pre_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre <= PRE_LAST);
  // R7: without a load the remaining time never grows
  a_r7_no_regrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ms_left <= $past(ms_left));
endmodule

// File: rtl/lcd_pwrup_seq.sv
module lcd_pwrup_seq
  import lps_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int RST_CYC    = 500,
  parameter int RECOVER_MS = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              lcd_rst_no,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic              m_dc_o,
  output logic [BYTE_W-1:0] m_data_o,
  output logic              done_o
);
  localparam int RC_W = $clog2(RST_CYC + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(STEPS - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [RC_W-1:0]  rst_cnt;
  logic             fin_r;
  step_t            step;
  logic             hs, tmr_load, tmr_done, rst_end;
  logic [MS_W-1:0]  tmr_ms;

  lps_rom u_rom (.idx_i(idx), .step_o(step));

  lps_ms_timer #(.CYC_PER_MS(CYC_PER_MS)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_ms_i(tmr_ms), .expired_o(tmr_done));

  always_comb begin
    hs       = (state == S_EMIT) && m_ready_i;
    rst_end  = (state == S_RST) && (rst_cnt == RC_LAST);
    tmr_load = rst_end || (hs && step.wait_ms != '0);
    tmr_ms   = (state == S_RST) ? MS_W'(RECOVER_MS) : step.wait_ms;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      idx     <= '0;
      rst_cnt <= '0;
      fin_r   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE: if (start_i) begin
          state   <= S_RST;
          rst_cnt <= '0;
          idx     <= '0;
          fin_r   <= 1'b0;
        end
        S_RST: begin
          rst_cnt <= rst_cnt + 1'b1;
          if (rst_end) state <= S_REC;
        end
        S_REC: if (tmr_done) state <= S_EMIT;
        S_EMIT: if (hs) begin
          idx   <= idx + 1'b1;
          fin_r <= (idx == IDX_LAST);
          if (step.wait_ms != '0) state <= S_WAIT;
        end
        S_WAIT: if (tmr_done) state <= fin_r ? S_DONE : S_EMIT;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign m_valid_o  = (state == S_EMIT);
  assign lcd_rst_no = (state != S_RST);
  assign done_o     = (state == S_DONE);
  assign m_dc_o     = step.is_data;
  assign m_data_o   = step.val;

  // R5: a stalled word is held
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_dc_o));
  // R2: nothing offered while the panel is held in reset
  a_r2_quiet_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcd_rst_no |-> !m_valid_o);
  // R3: recovery lasts until the timer expires
  a_r3_recover_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_REC && !tmr_done |=> state == S_REC);
  // R7: a pause lasts until the timer expires
  a_r7_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_WAIT && !tmr_done |=> state == S_WAIT);
  // R8: done is sticky without start and silences the stream
  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && !m_valid_o);
  // R9: start while running does not re-enter reset
  a_r9_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && lcd_rst_no && !done_o && state != S_IDLE |=> lcd_rst_no);
endmodule

// File: tb/lcd_pwrup_seq_test.sv
module lcd_pwrup_seq_test;
  localparam int CPM = 16;
  localparam int RCY = 6;
  localparam int RMS = 120;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ready = 1'b0;
  logic lcd_rst_n, valid, dc, done;
  logic [7:0] data;

  always #2.5 clk = ~clk;

  lcd_pwrup_seq #(.CYC_PER_MS(CPM), .RST_CYC(RCY), .RECOVER_MS(RMS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lcd_rst_no(lcd_rst_n),
    .m_valid_o(valid), .m_ready_i(ready), .m_dc_o(dc), .m_data_o(data),
    .done_o(done));

  typedef struct { bit dc; bit [7:0] v; int w; } item_t;
  item_t exp_q[$];
  int nchk = 0, nerr = 0;
  int words = 0, falls = 0, low_cnt = 0;
  int viol_r2 = 0, viol_r5 = 0, viol_r8 = 0;
  int gap = 0, lo = 0, hi = 0;
  bit meas = 0, done_seen = 0, prev_done = 0, prev_rst = 1;
  bit prev_stall = 0, prev_dc = 0;
  logic [7:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add(input bit d, input bit [7:0] v, input int w);
    item_t it;
    it.dc = d; it.v = v; it.w = w;
    exp_q.push_back(it);
  endtask

  task automatic push_seq();
    add(0, 8'hC1, 0); add(1, 8'hFF, 0); add(1, 8'h83, 0); add(1, 8'h40, 0);
    add(0, 8'h11, 150);
    add(0, 8'hCA, 0); add(1, 8'h70, 0); add(1, 8'h00, 0); add(1, 8'hD9, 0);
    add(0, 8'hB0, 0); add(1, 8'h01, 0); add(1, 8'h11, 0);
    add(0, 8'hC9, 0); add(1, 8'h90, 0); add(1, 8'h49, 0); add(1, 8'h10, 0);
    add(1, 8'h28, 0); add(1, 8'h28, 0); add(1, 8'h10, 0); add(1, 8'h00, 0);
    add(1, 8'h06, 20);
    add(0, 8'hB5, 0); add(1, 8'h35, 0); add(1, 8'h20, 0); add(1, 8'h45, 0);
    add(0, 8'hB4, 0); add(1, 8'h33, 0); add(1, 8'h25, 0); add(1, 8'h4C, 10);
    add(0, 8'h3A, 0); add(1, 8'h05, 0);
    add(0, 8'h29, 10);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // ready pattern: about three quarters high
  initial begin
    logic [7:0] lf = 8'hA5;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      ready = lf[0] | lf[1];
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (meas) gap++;
      if (!lcd_rst_n) low_cnt++;
      if (prev_rst && !lcd_rst_n) falls++;
      if (!prev_rst && lcd_rst_n) begin
        chk(low_cnt == RCY, "R2", "reset low cycles", low_cnt, RCY);
        low_cnt = 0;
        meas = 1; gap = 0; lo = RMS * CPM; hi = RMS * CPM + 4;
      end
      if (!lcd_rst_n && valid) viol_r2++;
      if (done && valid) viol_r8++;
      if (prev_stall && (!valid || data != prev_data || dc != prev_dc)) viol_r5++;
      if (valid && meas) begin
        if (lo == 1) chk(gap == 1, "R6", "gap between words", gap, 1);
        else if (lo == RMS * CPM) chk(gap >= lo && gap <= hi, "R3", "recovery gap", gap, lo);
        else chk(gap >= lo && gap <= hi, "R7", "pause gap", gap, lo);
        meas = 0;
      end
      if (valid && ready) begin
        words++;
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected word", data, -1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(data == it.v && dc == it.dc, "R4", "word {dc,byte}",
              {dc, data}, {it.dc, it.v});
          meas = 1; gap = 0;
          lo = (it.w == 0) ? 1 : it.w * CPM;
          hi = (it.w == 0) ? 1 : it.w * CPM + 4;
        end
      end
      if (done && !prev_done) begin
        chk(meas && gap >= 10 * CPM && gap <= 10 * CPM + 4, "R8",
            "done after final pause", gap, 10 * CPM);
        chk(exp_q.size() == 0, "R8", "words left at done", exp_q.size(), 0);
        meas = 0;
        done_seen = 1;
      end
      prev_done  = done;
      prev_rst   = lcd_rst_n;
      prev_stall = valid && !ready;
      prev_data  = data;
      prev_dc    = dc;
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "WDG", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!valid && !done && lcd_rst_n, "R1", "outputs in reset",
        {valid, done, lcd_rst_n}, 3'b001);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!valid && !done && lcd_rst_n, "R1", "idle outputs",
        {valid, done, lcd_rst_n}, 3'b001);

    // first run, with stray starts (R9)
    push_seq();
    pulse_start();
    repeat (2) @(negedge clk);
    start = 1'b1; @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk) start = 1'b0;
    wait (words >= 10);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait (words >= 14);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait (done_seen);
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R8", "done stays high", done, 1);
    chk(falls == 1, "R9", "reset pulses in first run", falls, 1);
    chk(words == 32, "R4", "words in first run", words, 32);

    // restart from done (R10)
    push_seq();
    done_seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done && !lcd_rst_n, "R10", "restart clears done, drives reset",
        {done, lcd_rst_n}, 2'b00);
    wait (done_seen);
    repeat (5) @(negedge clk);
    chk(falls == 2, "R10", "reset pulses after restart", falls, 2);
    chk(words == 64, "R10", "words after restart", words, 64);
    chk(viol_r2 == 0, "R2", "words during panel reset", viol_r2, 0);
    chk(viol_r5 == 0, "R5", "stalled word changed", viol_r5, 0);
    chk(viol_r8 == 0, "R8", "words while done", viol_r8, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule